// File: doc/BRIEF.md
# System Address and Register-Select Decoder

This block turns the 16-bit address bus and the active-low read and write pulses of a small processor system into chip enables and register strobes. The upper data space is carved into a boot ROM area, a memory-mapped I/O window and a host RAM area. The host RAM area is split into a battery-backed half and a general-purpose half. A data-buffer enable opens whenever either memory area is addressed.

Inside the I/O window, seven address bits are inverted to form active-low module selects. An eight-way register decoder serves the host's own registers. It uses the write pulse as its top select bit, so read strobes and write strobes come from one structure. One of its read codes has no register behind it. A read of that address only clears a fast-interrupt flag. The flag is held in a small register that sets on a rising edge of the request input and drives an active-low interrupt line.

Top module: `sys_addr_decoder`

## Requirements
- R1: For addresses 7000h–7FFFh, `nvram_ce_n` is low when address bit 11 is 0, and `sram_ce_n` is low when address bit 11 is 1. Neither is low outside that range.
- R2: `rom_ce_n` is low for addresses 0000h–5FFFh. Addresses 8000h–FFFFh leave every enable high. At most one of `nvram_ce_n`, `sram_ce_n`, `rom_ce_n` and `io_win_n` is low at any time.
- R3: `membuf_en_n` is low exactly when the host RAM area (7000h–7FFFh) or the ROM area (0000h–5FFFh) is addressed.
- R4: `io_win_n` is low for 6000h–6FFFh. While it is low, `mod_sel_n` equals the inverse of address bits 11..5. Otherwise `mod_sel_n` is all ones.
- R5: The register decoder is enabled only inside the I/O window with address bits 4 and 3 both 0. The selected code is {write, A1, A0}, where write is 1 when `wr_n` is low. The strobe for that code is bit `reg_sel_n[code]`, active low. At most one strobe is low.
- R6: Codes 4–7 (write codes) need `wr_n` low. Codes 0–2 (read codes) need `rd_n` low and `wr_n` high. With both pulses high, every strobe stays high. If both are low, the cycle is treated as a write.
- R7: Code 3 is unused: `reg_sel_n[3]` never goes low.
- R8: The interrupt flag sets when `fint_req` is sampled high at a clock edge after being sampled low at the edge before. `fint_irq_n` goes low right after that edge.
- R9: A read strobe of code 2 (address offset 2 of the window with bits 4..3 zero) clears the flag at the clock edge that samples it. If a set and a clear fall on the same edge, the clear wins. A write to the same offset has no effect on the flag.
- R10: Reset clears the flag (`fint_irq_n` high). A request held high through reset does not set the flag until it has gone low and risen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Processor address bus |
| rd_n | input | 1 | Active-low read pulse |
| wr_n | input | 1 | Active-low write pulse |
| fint_req | input | 1 | Fast-interrupt request, rising edge sets the flag |
| nvram_ce_n | output | 1 | Battery-backed RAM enable, active low |
| sram_ce_n | output | 1 | General RAM enable, active low |
| rom_ce_n | output | 1 | ROM area enable, active low |
| membuf_en_n | output | 1 | Memory data-buffer enable, active low |
| io_win_n | output | 1 | I/O window active, active low |
| mod_sel_n | output | 7 | Inverted middle address bits as module selects |
| reg_sel_n | output | 8 | Register strobes indexed by {write, A1, A0} |
| fint_irq_n | output | 1 | Fast-interrupt output, active low |

## Verification
The decode paths hold no state, so a wrong term shows at the ports in the same cycle the address is presented. It appears as a missing enable, an extra enable, or a strobe on the wrong code. The only internal state is the interrupt flag and the stored previous request. A fault there shows on `fint_irq_n` right after the first clock edge where a set or clear should have acted. One example is a flag that survives a clear read. Another is a spurious set after reset. The bench steps through range boundaries, every decoder code under read, write and idle pulses, and the same-edge set/clear collision.

// File: rtl/sad_pkg.sv
package sad_pkg;

    // Register decoder codes, {write, A1, A0}
    typedef enum logic [2:0] {
        RS_IRQ_STAT  = 3'd0,
        RS_MISC_IN   = 3'd1,
        RS_FINT_CLR  = 3'd2,
        RS_SPARE     = 3'd3,
        RS_CTRL      = 3'd4,
        RS_MISC_OUT  = 3'd5,
        RS_VIDEO     = 3'd6,
        RS_PROBE_LED = 3'd7
    } reg_code_e;

    localparam int unsigned REG_CODES = 8;

    // State of the fast-interrupt holder
    typedef struct packed {
        logic flag;
        logic req_prev;
    } fint_state_t;

endpackage

// File: rtl/mem_region_dec.sv
module mem_region_dec #(
    parameter int unsigned ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] ROM_END   = 16'h6000,
    parameter logic [ADDR_W-1:0] IO_BASE   = 16'h6000,
    parameter logic [ADDR_W-1:0] HRAM_BASE = 16'h7000,
    parameter logic [ADDR_W-1:0] HRAM_END  = 16'h8000,
    parameter int unsigned SPLIT_BIT = 11
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              nvram_ce_n,
    output logic              sram_ce_n,
    output logic              rom_ce_n,
    output logic              membuf_en_n,
    output logic              io_win
);

    logic in_rom;
    logic in_io;
    logic in_hram;

    always_comb begin
        in_rom  = (addr < ROM_END);
        in_io   = (addr >= IO_BASE) && (addr < HRAM_BASE);
        in_hram = (addr >= HRAM_BASE) && (addr < HRAM_END);

        nvram_ce_n  = !(in_hram && !addr[SPLIT_BIT]);
        sram_ce_n   = !(in_hram &&  addr[SPLIT_BIT]);
        rom_ce_n    = !in_rom;
        membuf_en_n = !(in_hram || in_rom);
        io_win      = in_io;
    end

endmodule

// File: rtl/io_select_dec.sv
module io_select_dec
    import sad_pkg::*;
#(
    parameter int unsigned SEL_W = 7
) (
    input  logic                 io_win,
    input  logic [SEL_W-1:0]     sel_bits,
    input  logic [1:0]           en_bits,
    input  logic [1:0]           low_bits,
    input  logic                 rd_n,
    input  logic                 wr_n,
    output logic [SEL_W-1:0]     mod_sel_n,
    output logic [REG_CODES-1:0] reg_sel_n,
    output logic                 fint_clr
);

    logic       dec_en;
    logic       wr_cyc;
    logic       bus_act;
    logic [2:0] code;

    always_comb begin
        mod_sel_n = io_win ? ~sel_bits : {SEL_W{1'b1}};
        dec_en    = io_win && (en_bits == 2'b00);
        wr_cyc    = !wr_n;
        code      = {wr_cyc, low_bits};
        bus_act   = wr_cyc ? 1'b1 : !rd_n;
    end

    for (genvar g = 0; g < REG_CODES; g++) begin : g_strobe
        if (g == int'(RS_SPARE)) begin : g_unused
            assign reg_sel_n[g] = 1'b1;
        end else begin : g_used
            assign reg_sel_n[g] = !(dec_en && bus_act && (code == 3'(g)));
        end
    end

    assign fint_clr = !reg_sel_n[RS_FINT_CLR];

endmodule

// File: rtl/fint_flag.sv
module fint_flag
    import sad_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic clr,
    output logic irq_n
);

    fint_state_t st_d;
    fint_state_t st_q;

    always_comb begin
        st_d          = st_q;
        st_d.req_prev = req;
        if (clr) begin
            st_d.flag = 1'b0;
        end else if (req && !st_q.req_prev) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flag     <= 1'b0;
            st_q.req_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_n = !st_q.flag;

endmodule

// File: rtl/sys_addr_decoder.sv
module sys_addr_decoder
    import sad_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned SEL_LO    = 5,
    parameter int unsigned SEL_W     = 7,
    parameter int unsigned EN_LO     = 3,
    parameter int unsigned SPLIT_BIT = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 rd_n,
    input  logic                 wr_n,
    input  logic                 fint_req,
    output logic                 nvram_ce_n,
    output logic                 sram_ce_n,
    output logic                 rom_ce_n,
    output logic                 membuf_en_n,
    output logic                 io_win_n,
    output logic [SEL_W-1:0]     mod_sel_n,
    output logic [REG_CODES-1:0] reg_sel_n,
    output logic                 fint_irq_n
);

    localparam int unsigned SEL_HI = SEL_LO + SEL_W - 1;

    logic io_win;
    logic fint_clr;

    mem_region_dec #(
        .ADDR_W    (ADDR_W),
        .SPLIT_BIT (SPLIT_BIT)
    ) u_region (
        .addr        (addr),
        .nvram_ce_n  (nvram_ce_n),
        .sram_ce_n   (sram_ce_n),
        .rom_ce_n    (rom_ce_n),
        .membuf_en_n (membuf_en_n),
        .io_win      (io_win)
    );

    io_select_dec #(
        .SEL_W (SEL_W)
    ) u_iosel (
        .io_win    (io_win),
        .sel_bits  (addr[SEL_HI:SEL_LO]),
        .en_bits   (addr[EN_LO+1:EN_LO]),
        .low_bits  (addr[1:0]),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .mod_sel_n (mod_sel_n),
        .reg_sel_n (reg_sel_n),
        .fint_clr  (fint_clr)
    );

    fint_flag u_fint (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (fint_req),
        .clr   (fint_clr),
        .irq_n (fint_irq_n)
    );

    assign io_win_n = !io_win;

    a_r2_area_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~nvram_ce_n, ~sram_ce_n, ~rom_ce_n, ~io_win_n}));

    a_r4_sel_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        io_win_n |-> (&mod_sel_n));

    a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~reg_sel_n));

    a_r6_no_pulse_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n && wr_n) |-> (&reg_sel_n));

    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel_n[RS_FINT_CLR] |=> fint_irq_n);

    a_r8_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (fint_req && !$past(fint_req) && reg_sel_n[RS_FINT_CLR]) |=> !fint_irq_n);

endmodule

// File: tb/sim_sys_addr_decoder.sv
module sim_sys_addr_decoder;

    localparam time PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h8000;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        fint_req = 1'b0;

    logic       nvram_ce_n, sram_ce_n, rom_ce_n, membuf_en_n, io_win_n, fint_irq_n;
    logic [6:0] mod_sel_n;
    logic [7:0] reg_sel_n;

    sys_addr_decoder u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
        .fint_req(fint_req), .nvram_ce_n(nvram_ce_n), .sram_ce_n(sram_ce_n),
        .rom_ce_n(rom_ce_n), .membuf_en_n(membuf_en_n), .io_win_n(io_win_n),
        .mod_sel_n(mod_sel_n), .reg_sel_n(reg_sel_n), .fint_irq_n(fint_irq_n)
    );

    always #(PERIOD/2) clk = ~clk;

    typedef struct {
        logic [20:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    logic  m_flag = 1'b0;
    logic  m_prev = 1'b1;

    function automatic logic [20:0] observed();
        return {nvram_ce_n, sram_ce_n, rom_ce_n, membuf_en_n, io_win_n,
                mod_sel_n, reg_sel_n, fint_irq_n};
    endfunction

    task automatic compare(input logic [20:0] exp, input string tag);
        n_chk++;
        if (observed() !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, observed(), exp);
        end
    endtask

    // Driver: apply one bus cycle at the falling edge and queue what the
    // outputs must show right after the following rising edge.
    task automatic step(input logic [15:0] a, input logic r, input logic w,
                        input logic rq, input string tag);
        logic       hram, rom, win, en, wr, act, set_e, clr_e;
        logic [2:0] code;
        logic [6:0] ms;
        logic [7:0] rs;
        item_t      it;
        @(negedge clk);
        addr = a; rd_n = r; wr_n = w; fint_req = rq;
        hram = (a >= 16'h7000) && (a < 16'h8000);
        rom  = (a < 16'h6000);
        win  = (a >= 16'h6000) && (a < 16'h7000);
        ms   = win ? ~a[11:5] : 7'h7F;
        en   = win && (a[4:3] == 2'b00);
        wr   = !w;
        code = {wr, a[1:0]};
        act  = wr ? 1'b1 : !r;
        rs   = 8'hFF;
        if (en && act && code != 3'd3) rs[code] = 1'b0;
        clr_e = (rs[2] == 1'b0);
        set_e = rq && !m_prev;
        if (clr_e) m_flag = 1'b0;
        else if (set_e) m_flag = 1'b1;
        m_prev = rq;
        it.exp = {!(hram && !a[11]), !(hram && a[11]), !rom, !(hram || rom),
                  !win, ms, rs, !m_flag};
        it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: pop expectations once the edge has been taken.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                compare(it.exp, it.tag);
            end
        end
    end

    task automatic do_reset(input logic rq);
        @(negedge clk);
        rst_n = 1'b0; fint_req = rq; addr = 16'h8000; rd_n = 1'b1; wr_n = 1'b1;
        m_flag = 1'b0; m_prev = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog (all reqs): actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        do_reset(1'b0);
        #1;
        compare(21'h1FFFFF, "R10 reset state, idle address");

        step(16'h7000, 0, 1, 0, "R1 nvram low end");
        step(16'h77FF, 0, 1, 0, "R1 nvram top");
        step(16'h7800, 1, 0, 0, "R1 sram bottom");
        step(16'h7FFF, 0, 1, 0, "R1 sram top, R3 buffer");
        step(16'h0000, 0, 1, 0, "R2 rom start");
        step(16'h5FFF, 0, 1, 0, "R2 rom end, R3 buffer");
        step(16'h8000, 0, 1, 0, "R2 upper space no enable");
        step(16'hFFFF, 1, 0, 0, "R2 R3 top address");
        step(16'h6000, 0, 1, 0, "R4 R5 read code 0");
        step(16'h6001, 0, 1, 0, "R5 read code 1");
        step(16'h6003, 0, 1, 0, "R7 spare code silent");
        step(16'h6004, 1, 0, 0, "R5 write code 4");
        step(16'h6FE1, 1, 0, 0, "R4 R5 write code 5");
        step(16'h6AA6, 1, 0, 0, "R4 R5 write code 6");
        step(16'h6007, 1, 0, 0, "R5 write code 7");
        step(16'h6008, 0, 1, 0, "R5 bit3 set disables");
        step(16'h6010, 1, 0, 0, "R5 bit4 set disables");
        step(16'h6FFF, 0, 1, 0, "R4 window end");
        step(16'h6001, 1, 1, 0, "R6 no pulse no strobe");
        step(16'h6002, 1, 0, 0, "R6 write pulse picks write code 6");
        step(16'h6002, 0, 0, 0, "R6 both pulses treated as write");

        step(16'h8000, 1, 1, 1, "R8 rising request sets flag");
        step(16'h8000, 1, 1, 1, "R8 held request keeps flag");
        step(16'h6002, 1, 0, 1, "R9 write to clear offset no effect");
        step(16'h6002, 1, 1, 1, "R9 idle at clear offset no effect");
        step(16'h6002, 0, 1, 1, "R9 read clears flag");
        step(16'h8000, 1, 1, 0, "R8 request low");
        step(16'h6002, 0, 1, 1, "R9 clear wins over same-edge set");
        step(16'h8000, 1, 1, 0, "R8 request low again");
        step(16'h8000, 1, 1, 1, "R8 second rise sets");

        do_reset(1'b1);
        step(16'h8000, 1, 1, 1, "R10 request high through reset no set");
        step(16'h8000, 1, 1, 0, "R10 request drops");
        step(16'h8000, 1, 1, 1, "R10 new rise sets");
        step(16'h8000, 1, 1, 1, "R8 flag held");

        @(negedge clk);
        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule